// File: doc/BRIEF.md
# Serial Power-Bus Command Channel

This block is one command channel of a power-management bus master, as seen from a simple register bus. Software loads up to eight payload bytes into two 32-bit staging words and then writes a command word. The command word carries the opcode, the target slave number, a register address and a byte count. Writing the command word starts one transaction. When the channel is idle it clears its status word. It then checks the opcode and the ownership of the target slave, and runs the transfer one byte per cycle against an internal model of sixteen slave register files. At the end it sets a done flag, qualified by failure, denied and dropped flags.

Bytes returned by a read land in two read-data words, lowest address in the lowest byte lane. The channel always finishes. A transfer that reaches past the modelled register file is never acknowledged by the model, and a timeout counter closes it with a failure. A command written while a transaction is running is discarded. The discard is remembered and reported with the final status.

Top module: `cmdch_top`

## Requirements
- R1: The word at bus address 0x000 reads the VERSION parameter. An address that maps to no register reads zero.
- R2: The channel window starts at 0x800 + 0x80*CHAN. Within the window, the offsets are:
  - command at 0x00
  - config at 0x04
  - status at 0x08
  - write-data word 0 at 0x10 and word 1 at 0x14
  - read-data word 0 at 0x18 and word 1 at 0x1C

  Config and both write-data words read back what was last written to them.
- R3: The command word holds four fields:
  - opcode in bits 31:27
  - slave number in bits 23:20
  - address in bits 19:4
  - byte-count-minus-one in bits 2:0

  A command written while idle clears the status word and both read-data words on the next clock edge.
- R4: Long write (opcode 0) and extended write (opcode 2) move count bytes to consecutive slave registers starting at the effective address. Byte i comes from lane i of write-data word 0 for i<4, and from lane i-4 of word 1 otherwise. Done (status bit 0) appears count+1 edges after the command edge.
- R5: Long read (opcode 1) and extended read (opcode 13) place byte i into the same lane layout in the read-data words. Lanes beyond the count read zero.
- R6: The effective address depends on the opcode:
  - long opcodes (0, 1) use all 16 address bits
  - extended opcodes (2, 13) use address bits 7:0
  - short write (14) and short read (15) use address bits 4:0 and always move exactly one byte
- R7: Zero write (opcode 16) writes address bits 6:0 as the data byte into register 0 of the slave. It moves one byte.
- R8: Control opcodes 3, 4, 5 and 6 finish one edge after the command edge with status 0x1 and change no slave register.
- R9: Any other opcode starts no transfer. It finishes one edge after the command edge with status 0x3 (done and failure, bit 1).
- R10: A command to a slave whose bit in OWN_MASK is clear finishes one edge after the command edge with status 0x5 (done and denied, bit 2). It changes no register and leaves the read-data words at zero.
- R11: A transfer whose effective address plus count exceeds NREG gets no acknowledge. It finishes TIMEOUT+1 edges after the command edge with status 0x3.
- R12: A command written while a transaction is running is discarded. The running transaction's final status additionally carries dropped (bit 3).
- R13: Every accepted command sets done exactly once, within TIMEOUT+1 edges. Done stays clear until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
Each transaction is visible through the status word on every cycle between launch and completion. A wrong engine state therefore shows up at the first cycle where done or an error bit differs from the expected timeline: early, late, missing or doubled. A wrong byte index or address mask in the engine corrupts either the read-data lanes seen right after done, or the slave contents that a follow-up read command returns a few cycles later. Dropped and denied paths are exposed by a read-back that must show untouched registers.

// File: rtl/cmdch_pkg.sv
package cmdch_pkg;

  localparam int unsigned SID_W  = 4;
  localparam int unsigned ADDR_W = 16;

  // status bit positions
  localparam int unsigned ST_DONE   = 0;
  localparam int unsigned ST_FAIL   = 1;
  localparam int unsigned ST_DENIED = 2;
  localparam int unsigned ST_DROP   = 3;

  // register offsets inside a channel window
  localparam logic [6:0] OFF_CMD  = 7'h00;
  localparam logic [6:0] OFF_CFG  = 7'h04;
  localparam logic [6:0] OFF_STAT = 7'h08;
  localparam logic [6:0] OFF_WD0  = 7'h10;
  localparam logic [6:0] OFF_WD1  = 7'h14;
  localparam logic [6:0] OFF_RD0  = 7'h18;
  localparam logic [6:0] OFF_RD1  = 7'h1C;

  typedef enum logic [4:0] {
    OP_LWR   = 5'd0,
    OP_LRD   = 5'd1,
    OP_XWR   = 5'd2,
    OP_RESET = 5'd3,
    OP_SLEEP = 5'd4,
    OP_SHDN  = 5'd5,
    OP_WAKE  = 5'd6,
    OP_XRD   = 5'd13,
    OP_SWR   = 5'd14,
    OP_SRD   = 5'd15,
    OP_ZWR   = 5'd16
  } opcode_e;

  typedef enum logic [1:0] {
    K_BAD,
    K_CTRL,
    K_WRITE,
    K_READ
  } kind_e;

  typedef struct packed {
    logic [4:0]        op;
    logic [SID_W-1:0]  sid;
    logic [ADDR_W-1:0] addr;
    logic [2:0]        cnt_m1;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [31:0] w);
    cmd_t c;
    c.op     = w[31:27];
    c.sid    = w[23:20];
    c.addr   = w[19:4];
    c.cnt_m1 = w[2:0];
    return c;
  endfunction

  function automatic logic [7:0] get_lane(input logic [63:0] d, input logic [2:0] i);
    return d[{3'b000, i} * 8 +: 8];
  endfunction

  function automatic logic [63:0] put_lane(input logic [63:0] d, input logic [2:0] i,
                                           input logic [7:0] b);
    logic [63:0] r;
    r = d;
    r[{3'b000, i} * 8 +: 8] = b;
    return r;
  endfunction

  // true when a transfer of n bytes at base a stays inside nreg registers
  function automatic logic span_fits(input logic [ADDR_W-1:0] a, input logic [3:0] n,
                                     input int unsigned nreg);
    logic [ADDR_W:0] last;
    last = {1'b0, a} + {{(ADDR_W-3){1'b0}}, n};
    return last <= (ADDR_W+1)'(nreg);
  endfunction

endpackage

// File: rtl/cmdch_decode.sv
module cmdch_decode
  import cmdch_pkg::*;
(
  input  logic [4:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        cnt_m1_i,
  output kind_e             kind_o,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [3:0]        nbytes_o,
  output logic              zero_wr_o,
  output logic [7:0]        zero_data_o
);

  logic [3:0] full_n;
  assign full_n      = {1'b0, cnt_m1_i} + 4'd1;
  assign zero_data_o = {1'b0, addr_i[6:0]};

  always_comb begin
    kind_o     = K_BAD;
    eff_addr_o = addr_i;
    nbytes_o   = full_n;
    zero_wr_o  = 1'b0;
    case (op_i)
      OP_LWR:  kind_o = K_WRITE;
      OP_LRD:  kind_o = K_READ;
      OP_XWR: begin
        kind_o     = K_WRITE;
        eff_addr_o = {8'h00, addr_i[7:0]};
      end
      OP_XRD: begin
        kind_o     = K_READ;
        eff_addr_o = {8'h00, addr_i[7:0]};
      end
      OP_SWR: begin
        kind_o     = K_WRITE;
        eff_addr_o = {11'h000, addr_i[4:0]};
        nbytes_o   = 4'd1;
      end
      OP_SRD: begin
        kind_o     = K_READ;
        eff_addr_o = {11'h000, addr_i[4:0]};
        nbytes_o   = 4'd1;
      end
      OP_ZWR: begin
        kind_o     = K_WRITE;
        eff_addr_o = '0;
        nbytes_o   = 4'd1;
        zero_wr_o  = 1'b1;
      end
      OP_RESET, OP_SLEEP, OP_SHDN, OP_WAKE: kind_o = K_CTRL;
      default: kind_o = K_BAD;
    endcase
  end

endmodule

// File: rtl/cmdch_slave_model.sv
module cmdch_slave_model
  import cmdch_pkg::*;
#(
  parameter int unsigned NREG = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [SID_W-1:0]         sid,
  input  logic [$clog2(NREG)-1:0]  reg_idx,
  input  logic [7:0]               wbyte,
  output logic [7:0]               rbyte
);

  localparam int unsigned NSLV   = 1 << SID_W;
  localparam int unsigned REG_AW = $clog2(NREG);
  localparam int unsigned DEPTH  = NSLV * NREG;
  localparam int unsigned IDX_W  = SID_W + REG_AW;

  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] flat;

  assign flat  = {sid, reg_idx};
  assign rbyte = mem[flat];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[flat] <= wbyte;
    end
  end

endmodule

// File: rtl/cmdch_engine.sv
module cmdch_engine
  import cmdch_pkg::*;
#(
  parameter int unsigned     NREG     = 16,
  parameter int unsigned     TIMEOUT  = 32,
  parameter logic [15:0]     OWN_MASK = 16'hFF7F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     launch,
  input  kind_e                    kind_i,
  input  logic [SID_W-1:0]         sid_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [3:0]               nbytes_i,
  input  logic                     zero_wr_i,
  input  logic [7:0]               zero_data_i,
  input  logic [63:0]              wdata_i,
  output logic                     busy,
  output logic                     finish,
  output logic                     fin_fail,
  output logic                     fin_denied,
  output logic                     mem_we,
  output logic [SID_W-1:0]         mem_sid,
  output logic [$clog2(NREG)-1:0]  mem_reg,
  output logic [7:0]               mem_wbyte,
  output logic                     rd_we,
  output logic [2:0]               rd_lane
);

  localparam int unsigned REG_AW = $clog2(NREG);
  localparam int unsigned CNT_W  = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_XFER, S_STALL} state_e;

  state_e            st_q;
  kind_e             kind_q;
  logic [SID_W-1:0]  sid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        n_q;
  logic              zw_q;
  logic [7:0]        zd_q;
  logic [63:0]       wd_q;
  logic [2:0]        idx_q;
  logic [CNT_W-1:0]  cnt_q;

  logic owned, data_op, fits, go_xfer, go_stall, last_byte, stall_end;
  logic [ADDR_W-1:0] cur_addr;

  assign owned     = OWN_MASK[sid_q];
  assign data_op   = (kind_q == K_WRITE) || (kind_q == K_READ);
  assign fits      = span_fits(addr_q, n_q, NREG);
  assign go_xfer   = data_op && owned && fits;
  assign go_stall  = data_op && owned && !fits;
  assign last_byte = ({1'b0, idx_q} == (n_q - 4'd1));
  assign stall_end = (cnt_q == CNT_W'(TIMEOUT - 1));
  assign cur_addr  = addr_q + {{(ADDR_W-3){1'b0}}, idx_q};

  assign busy       = (st_q != S_IDLE);
  assign finish     = ((st_q == S_CHECK) && !go_xfer && !go_stall) ||
                      ((st_q == S_XFER) && last_byte) ||
                      ((st_q == S_STALL) && stall_end);
  assign fin_fail   = ((st_q == S_CHECK) && (kind_q == K_BAD)) || (st_q == S_STALL);
  assign fin_denied = (st_q == S_CHECK) && (kind_q != K_BAD) && !owned;

  assign mem_sid   = sid_q;
  assign mem_reg   = cur_addr[REG_AW-1:0];
  assign mem_wbyte = zw_q ? zd_q : get_lane(wd_q, idx_q);
  assign mem_we    = (st_q == S_XFER) && (kind_q == K_WRITE);
  assign rd_we     = (st_q == S_XFER) && (kind_q == K_READ);
  assign rd_lane   = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      kind_q <= K_BAD;
      sid_q  <= '0;
      addr_q <= '0;
      n_q    <= 4'd1;
      zw_q   <= 1'b0;
      zd_q   <= 8'h00;
      wd_q   <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (launch) begin
          st_q   <= S_CHECK;
          kind_q <= kind_i;
          sid_q  <= sid_i;
          addr_q <= addr_i;
          n_q    <= nbytes_i;
          zw_q   <= zero_wr_i;
          zd_q   <= zero_data_i;
          wd_q   <= wdata_i;
        end
        S_CHECK: begin
          idx_q <= '0;
          cnt_q <= '0;
          if (go_xfer)       st_q <= S_XFER;
          else if (go_stall) st_q <= S_STALL;
          else               st_q <= S_IDLE;
        end
        S_XFER: begin
          if (last_byte) st_q <= S_IDLE;
          else           idx_q <= idx_q + 3'd1;
        end
        S_STALL: begin
          if (stall_end) st_q <= S_IDLE;
          else           cnt_q <= cnt_q + CNT_W'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmdch_top.sv
module cmdch_top
  import cmdch_pkg::*;
#(
  parameter int unsigned CHAN     = 2,
  parameter int unsigned NREG     = 16,
  parameter int unsigned TIMEOUT  = 32,
  parameter logic [15:0] OWN_MASK = 16'hFF7F,
  parameter logic [31:0] VERSION  = 32'h0005_0A01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wen,
  input  logic [15:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  localparam int unsigned REG_AW  = $clog2(NREG);
  localparam logic [15:0] WIN_BASE = 16'(32'h0800 + 32'h0080 * CHAN);

  // register decode
  logic       in_win;
  logic [6:0] off;
  assign in_win = (bus_addr[15:7] == WIN_BASE[15:7]);
  assign off    = bus_addr[6:0];

  logic wr_cmd, wr_cfg, wr_wd0, wr_wd1;
  assign wr_cmd = bus_wen && in_win && (off == OFF_CMD);
  assign wr_cfg = bus_wen && in_win && (off == OFF_CFG);
  assign wr_wd0 = bus_wen && in_win && (off == OFF_WD0);
  assign wr_wd1 = bus_wen && in_win && (off == OFF_WD1);

  // named internal events
  logic launch, drop_evt, busy, finish, fin_fail, fin_denied;
  assign launch   = wr_cmd && !busy;
  assign drop_evt = wr_cmd && busy;

  // command field unpacking and opcode classification
  cmd_t              cmd;
  kind_e             dec_kind;
  logic [ADDR_W-1:0] dec_addr;
  logic [3:0]        dec_n;
  logic              dec_zw;
  logic [7:0]        dec_zd;
  assign cmd = unpack_cmd(bus_wdata);

  cmdch_decode u_dec (
    .op_i        (cmd.op),
    .addr_i      (cmd.addr),
    .cnt_m1_i    (cmd.cnt_m1),
    .kind_o      (dec_kind),
    .eff_addr_o  (dec_addr),
    .nbytes_o    (dec_n),
    .zero_wr_o   (dec_zw),
    .zero_data_o (dec_zd)
  );

  // software registers
  logic [31:0] wd0_q, wd1_q, cfg_q;
  logic [63:0] rd_q;
  logic [3:0]  stat_q;
  logic        drop_pend_q;

  logic                mem_we, rd_we;
  logic [SID_W-1:0]    mem_sid;
  logic [REG_AW-1:0]   mem_reg;
  logic [7:0]          mem_wbyte, mem_rbyte;
  logic [2:0]          rd_lane;

  cmdch_engine #(
    .NREG     (NREG),
    .TIMEOUT  (TIMEOUT),
    .OWN_MASK (OWN_MASK)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .kind_i      (dec_kind),
    .sid_i       (cmd.sid),
    .addr_i      (dec_addr),
    .nbytes_i    (dec_n),
    .zero_wr_i   (dec_zw),
    .zero_data_i (dec_zd),
    .wdata_i     ({wd1_q, wd0_q}),
    .busy        (busy),
    .finish      (finish),
    .fin_fail    (fin_fail),
    .fin_denied  (fin_denied),
    .mem_we      (mem_we),
    .mem_sid     (mem_sid),
    .mem_reg     (mem_reg),
    .mem_wbyte   (mem_wbyte),
    .rd_we       (rd_we),
    .rd_lane     (rd_lane)
  );

  cmdch_slave_model #(.NREG(NREG)) u_slv (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .sid     (mem_sid),
    .reg_idx (mem_reg),
    .wbyte   (mem_wbyte),
    .rbyte   (mem_rbyte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd0_q       <= '0;
      wd1_q       <= '0;
      cfg_q       <= '0;
      rd_q        <= '0;
      stat_q      <= '0;
      drop_pend_q <= 1'b0;
    end else begin
      if (wr_wd0) wd0_q <= bus_wdata;
      if (wr_wd1) wd1_q <= bus_wdata;
      if (wr_cfg) cfg_q <= bus_wdata;
      if (launch) begin
        stat_q      <= '0;
        rd_q        <= '0;
        drop_pend_q <= 1'b0;
      end else begin
        if (rd_we) rd_q <= put_lane(rd_q, rd_lane, mem_rbyte);
        if (finish) begin
          stat_q[ST_DONE]   <= 1'b1;
          stat_q[ST_FAIL]   <= fin_fail;
          stat_q[ST_DENIED] <= fin_denied;
          stat_q[ST_DROP]   <= drop_pend_q || drop_evt;
          drop_pend_q       <= 1'b0;
        end else if (drop_evt) begin
          drop_pend_q <= 1'b1;
        end
      end
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 16'h0000) begin
      bus_rdata = VERSION;
    end else if (in_win) begin
      case (off)
        OFF_CFG:  bus_rdata = cfg_q;
        OFF_STAT: bus_rdata = {28'h0, stat_q};
        OFF_WD0:  bus_rdata = wd0_q;
        OFF_WD1:  bus_rdata = wd1_q;
        OFF_RD0:  bus_rdata = rd_q[31:0];
        OFF_RD1:  bus_rdata = rd_q[63:32];
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/cmdch_checker.sv
module cmdch_checker #(
  parameter int unsigned TIMEOUT  = 32,
  parameter logic [15:0] OWN_MASK = 16'hFF7F
) (
  input logic       clk,
  input logic       rst_n,
  input logic       launch,
  input logic       finish,
  input logic       drop_evt,
  input logic       busy,
  input logic [3:0] stat_q,
  input logic       mem_we,
  input logic [3:0] mem_sid
);

  localparam int unsigned LIMIT = TIMEOUT + 10;

  int unsigned busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  AST_CLR_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (stat_q == 4'h0)); // R3
  AST_DONE_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> stat_q[0]); // R13
  AST_DONE_ONLY_FROM_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[0]) |-> $past(finish)); // R13
  AST_BOUNDED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= LIMIT); // R13
  AST_DROP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> (busy && !launch)); // R12
  AST_WRITE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> OWN_MASK[mem_sid]); // R10

endmodule

bind cmdch_top cmdch_checker #(.TIMEOUT(TIMEOUT), .OWN_MASK(OWN_MASK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .launch   (launch),
  .finish   (finish),
  .drop_evt (drop_evt),
  .busy     (busy),
  .stat_q   (stat_q),
  .mem_we   (mem_we),
  .mem_sid  (mem_sid)
);

// File: tb/sim_cmdch_top.sv
`timescale 1ns/1ps
module sim_cmdch_top;

  localparam int CHAN = 2;
  localparam int NREG = 16;
  localparam int TMO  = 32;
  localparam logic [15:0] OWN = 16'hFF7F;
  localparam logic [31:0] VER = 32'h0005_0A01;
  localparam logic [15:0] BASE = 16'h0800 + 16'h0080 * CHAN;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  always #4 clk = ~clk;

  cmdch_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int nvec = 0;
  int nbad = 0;
  bit finished = 0;

  // behavioural reference state
  byte unsigned smem [16][16];
  logic [31:0]  m_wd0, m_wd1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    bus_wen = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_wd(input logic [31:0] w0, input logic [31:0] w1);
    bus_write(BASE + 16'h10, w0);
    bus_write(BASE + 16'h14, w1);
    m_wd0 = w0; m_wd1 = w1;
  endtask

  function automatic logic [31:0] cmd_word(int op, int sid, int addr, int cm1);
    return (32'(op) << 27) | (32'(sid & 15) << 20) | (32'(addr & 16'hFFFF) << 4) | 32'(cm1 & 7);
  endfunction

  // issue one command, compare status every cycle, then read-data words
  task automatic run_cmd(input string req, input int op, input int sid, input int addr,
                         input int cm1, input int drop_at);
    int ea, n, lat;
    logic [31:0] est, v;
    logic [63:0] erd, wd;
    bit is_rd, is_wr;
    wd = {m_wd1, m_wd0};
    erd = '0; is_rd = 0; is_wr = 0; n = cm1 + 1; ea = addr;
    case (op)
      0: begin is_wr = 1; end
      1: begin is_rd = 1; end
      2: begin is_wr = 1; ea = addr % 256; end
      13: begin is_rd = 1; ea = addr % 256; end
      14: begin is_wr = 1; ea = addr % 32; n = 1; end
      15: begin is_rd = 1; ea = addr % 32; n = 1; end
      16: begin is_wr = 1; ea = 0; n = 1; end
      default: ;
    endcase
    if (!is_rd && !is_wr && !(op >= 3 && op <= 6)) begin est = 32'h3; lat = 1; end
    else if (!OWN[sid]) begin est = 32'h5; lat = 1; end
    else if (op >= 3 && op <= 6) begin est = 32'h1; lat = 1; end
    else if (ea + n > NREG) begin est = 32'h3; lat = 1 + TMO; end
    else begin
      est = 32'h1; lat = 1 + n;
      for (int i = 0; i < n; i++) begin
        if (op == 16) smem[sid][0] = byte'(addr & 8'h7F);
        else if (is_wr) smem[sid][ea+i] = wd[i*8 +: 8];
        else erd[i*8 +: 8] = smem[sid][ea+i];
      end
    end
    if (drop_at >= 0) est = est | 32'h8;
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = BASE; bus_wdata = cmd_word(op, sid, addr, cm1);
    for (int k = 0; k <= lat; k++) begin
      @(negedge clk);
      bus_read(BASE + 16'h08, v);
      chk({req, " status timeline"}, v, (k == lat) ? est : 32'h0);
      if (k == drop_at) begin
        bus_wen = 1'b1; bus_addr = BASE; bus_wdata = cmd_word(0, sid, 0, 7);
      end
    end
    @(negedge clk);
    bus_read(BASE + 16'h18, v); chk({req, " rdata0"}, v, erd[31:0]);
    bus_read(BASE + 16'h1C, v); chk({req, " rdata1"}, v, erd[63:32]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    for (int s = 0; s < 16; s++) for (int r = 0; r < 16; r++) smem[s][r] = 8'h00;
    m_wd0 = '0; m_wd1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / reset state
    bus_read(16'h0000, v);        chk("R1 version", v, VER);
    bus_read(BASE + 16'h08, v);   chk("R3 reset status", v, 32'h0);
    bus_read(BASE + 16'h18, v);   chk("R5 reset rdata0", v, 32'h0);
    bus_read(16'h0004, v);        chk("R1 unmapped", v, 32'h0);
    // R2 staging and config readback
    bus_write(BASE + 16'h04, 32'hA5A5_0003);
    set_wd(32'h4433_2211, 32'h8877_6655);
    bus_read(BASE + 16'h04, v);   chk("R2 config", v, 32'hA5A5_0003);
    bus_read(BASE + 16'h10, v);   chk("R2 wdata0", v, 32'h4433_2211);
    bus_read(BASE + 16'h14, v);   chk("R2 wdata1", v, 32'h8877_6655);
    bus_read(BASE + 16'h0C, v);   chk("R2 hole", v, 32'h0);
    // R4 long write 8 bytes, R5 long read back
    run_cmd("R4 long write", 0, 3, 2, 7, -1);
    run_cmd("R5 long read", 1, 3, 2, 7, -1);
    // R5 R6 extended read, high address bits dropped, partial lanes zero
    run_cmd("R6 ext read", 13, 3, 16'h1203, 2, -1);
    // R6 extended write then read
    set_wd(32'hDEAD_BEEF, 32'h0);
    run_cmd("R6 ext write", 2, 6, 16'h0F0A, 1, -1);
    run_cmd("R6 ext readback", 1, 6, 10, 3, -1);
    // R6 short write: one byte only at addr[4:0]
    set_wd(32'h0000_C3C2, 32'h0);
    run_cmd("R6 short write", 14, 5, 16'hFFE1, 5, -1);
    run_cmd("R6 short readback", 1, 5, 0, 3, -1);
    run_cmd("R6 short read", 15, 5, 16'h0041, 7, -1);
    // R7 zero write
    run_cmd("R7 zero write", 16, 4, 16'h00DA, 3, -1);
    run_cmd("R7 zero readback", 1, 4, 0, 1, -1);
    // R8 control opcodes
    run_cmd("R8 sleep", 4, 3, 0, 0, -1);
    run_cmd("R8 wake", 6, 3, 0, 0, -1);
    // R9 unsupported opcode then unchanged
    run_cmd("R9 bad op", 9, 3, 2, 7, -1);
    run_cmd("R9 bad op 31", 31, 3, 2, 7, -1);
    run_cmd("R9 readback", 1, 3, 2, 7, -1);
    // R10 denied
    run_cmd("R10 denied write", 0, 7, 0, 3, -1);
    run_cmd("R10 denied read", 1, 7, 0, 3, -1);
    // R11 timeout
    run_cmd("R11 timeout", 1, 3, 14, 3, -1);
    run_cmd("R11 timeout ext", 2, 3, 16'h0020, 0, -1);
    // R12 drop during busy, second command must not write
    set_wd(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_cmd("R12 dropped", 1, 3, 2, 7, 3);
    run_cmd("R12 readback", 1, 3, 2, 7, -1);
    run_cmd("R12 drop on ctrl", 5, 3, 0, 0, 0);
    // R13 back-to-back commands keep working
    run_cmd("R13 after drop", 15, 3, 2, 0, -1);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule